// File: doc/BRIEF.md
# Teletext request window generator

The block makes a single-bit request strobe that asks an external teletext data source to supply bits during the active teletext window of a video line. Each line begins with a one-cycle start pulse. If the line is marked as carrying teletext, the strobe opens after a programmable number of pixel clocks and closes at the end of the data window. With both offsets at zero, the window is wide enough for the nominal 360-bit teletext payload.

One 8-bit control register, reached through a small write port, holds two 4-bit offsets. The upper nibble delays the opening edge by 0 to 15 pixel clocks. The lower nibble pulls the closing edge earlier by 0 to 15 pixel clocks, which shortens the window and so requests fewer bits. When the lower nibble is zero, the closing edge is not fixed to the line. It follows the opening edge, so the window width stays at its nominal value whatever opening delay is chosen.

The offsets are captured at each start pulse. A register write therefore takes effect from the next line and never distorts a window that is already open.

Top module: `ttx_req_window`

## Requirements
- R1: After reset the control register holds 00h and `ttx_req` is low.
- R2: A write with `wr_en` high and `wr_addr` equal to 1Ch loads `wr_data` into the control register at that clock edge. Writes to any other address leave the register, and therefore later windows, unchanged.
- R3: Control bits 7:4 give the opening delay R. If `line_start` and `line_en` are sampled high at edge k, `ttx_req` goes high after edge k+R.
- R4: When control bits 3:0 are zero, the closing edge tracks the opening edge. `ttx_req` stays high for exactly BASE_W = 1401 cycles (the default parameters) and falls after edge k+R+1401.
- R5: When control bits 3:0 hold a nonzero value F, `ttx_req` falls after edge k+1401-F, independent of R. The window is then 1401-F-R cycles wide.
- R6: A start pulse sampled with `line_en` low produces no request on that line and ends any window that is open.
- R7: The offsets in use are those held in the register at the start pulse. A write during an open window changes only later lines.
- R8: A start pulse sampled during an open window restarts the timing from that edge.
- R9: Once a window has closed, `ttx_req` stays low until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse marking the start of the teletext window timing |
| line_en | input | 1 | High when the current line carries teletext, sampled with `line_start` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address; the control register is at 1Ch |
| wr_data | input | 8 | Register write data: bits 7:4 opening delay, bits 3:0 closing pull-in |
| ttx_req | output | 1 | Teletext data request strobe |

## Verification
The assertions take for granted that `line_en` is valid whenever `line_start` is high. They also assume that write address and data are known whenever `wr_en` is high. The width bound assumes the nominal window is longer than 30 cycles, so that the closing point always lies after the opening point.

The stimulus drives every input at the falling clock edge and never holds a start pulse for more than one edge. Random lines mix offsets, enable states and mid-window events such as writes, stray-address writes and restarts. Directed lines cover the offset extremes 0 and 15 in each field.

// File: rtl/ttx_req_window.sv
module ttx_req_window #(
  parameter int WINDOW_BITS = 360,
  parameter int CLK_KHZ     = 27000,
  parameter int BIT_KHZ     = 6937,
  parameter int AW          = 5,
  parameter logic [AW-1:0] CTRL_ADDR = 5'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          line_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          ttx_req
);
  localparam int BASE_W = (WINDOW_BITS * CLK_KHZ + BIT_KHZ / 2) / BIT_KHZ;
  localparam int CW     = $clog2(BASE_W + 17);

  logic [7:0]    ctrl;
  logic [CW-1:0] cnt, rise_q, fall_q;
  logic          armed;

  wire [3:0]    rise_d = ctrl[7:4];
  wire [3:0]    fall_d = ctrl[3:0];
  wire [CW-1:0] rise_t = CW'(rise_d);
  wire [CW-1:0] fall_t = (fall_d == 4'd0) ? CW'(BASE_W) + CW'(rise_d)
                                          : CW'(BASE_W) - CW'(fall_d);
  wire [CW-1:0] cnt_inc = cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            ctrl <= 8'h00;
    else if (wr_en && wr_addr == CTRL_ADDR) ctrl <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rise_q <= '0;
      fall_q <= '0;
      armed  <= 1'b0;
    end else if (line_start) begin
      cnt    <= '0;
      rise_q <= rise_t;
      fall_q <= fall_t;
      armed  <= line_en;
    end else if (armed) begin
      cnt <= cnt_inc;
      if (cnt_inc >= fall_q) armed <= 1'b0;
    end
  end

  assign ttx_req = armed && (cnt >= rise_q) && (cnt < fall_q);
endmodule

module ttx_req_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_start,
  input logic        line_en,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        ttx_req,
  input logic [7:0]  ctrl,
  input logic [15:0] fall_pt
);
  logic [15:0] hi_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          hi_run <= '0;
    else if (line_start) hi_run <= '0;
    else if (ttx_req)    hi_run <= hi_run + 16'd1;
    else                 hi_run <= '0;

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 5'h1C |=> ctrl == $past(wr_data)); // R2
  AST_WR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 5'h1C) |=> $stable(ctrl)); // R2
  AST_RISE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && line_en && ctrl[7:4] == 4'd0 |=> ttx_req); // R3
  AST_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && line_en && ctrl[7:4] != 4'd0 |=> !ttx_req); // R3
  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ttx_req |-> hi_run < fall_pt); // R4
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !line_en |=> !ttx_req); // R6
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ttx_req) && !$past(line_start) && !line_start |=> !ttx_req); // R9
endmodule

bind ttx_req_window ttx_req_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_en(line_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ttx_req(ttx_req),
  .ctrl(ctrl), .fall_pt(16'(fall_q))
);

// File: tb/ttx_req_window_bench.sv
module ttx_req_window_bench;
  localparam int BASE = 1401;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic       line_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ttx_req;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] mctrl = 8'h00;

  always #4 clk = ~clk;

  ttx_req_window u_ttx_req_window (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_en(line_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ttx_req(ttx_req)
  );

  function automatic bit exp_req(int t, int r, int f, bit en);
    int fe;
    fe = (f == 0) ? BASE + r : BASE - f;
    return en && t >= r && t < fe;
  endfunction

  task automatic check(bit got, bit exp, string tag, int t);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0d ttx_req=%0b expected %0b", tag, t, got, exp);
    end
  endtask

  task automatic write_reg(logic [4:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (a == 5'h1C) mctrl = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // kind: 0 none, 1 write ctrl, 2 write other address, 3 restart with line_en=data[0]
  task automatic do_line(bit en, int ev_at, int kind, logic [7:0] ev_data, string tag);
    int r, f, t, n;
    bit len;
    r = int'(mctrl[7:4]); f = int'(mctrl[3:0]); len = en;
    line_start = 1'b1; line_en = en;
    @(posedge clk);
    @(negedge clk);
    t = 0;
    n = BASE + 24 + ((kind == 3) ? ev_at + 1 : 0);
    for (int i = 0; i < n; i++) begin
      check(ttx_req, exp_req(t, r, f, len), tag, t);
      line_start = 1'b0; wr_en = 1'b0;
      if (i == ev_at) begin
        case (kind)
          1: begin wr_en = 1'b1; wr_addr = 5'h1C; wr_data = ev_data; end
          2: begin wr_en = 1'b1; wr_addr = 5'h03; wr_data = ev_data; end
          3: begin line_start = 1'b1; line_en = ev_data[0]; end
          default: ;
        endcase
      end
      @(posedge clk);
      if (i == ev_at && kind == 1) mctrl = ev_data;
      if (i == ev_at && kind == 3) begin
        r = int'(mctrl[7:4]); f = int'(mctrl[3:0]); len = ev_data[0]; t = 0;
      end else t++;
      @(negedge clk);
    end
    line_start = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(ttx_req, 1'b0, "R1 reset output", i);
      @(negedge clk);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(ttx_req, 1'b0, "R1 idle after reset", 0);

    do_line(1'b1, -1, 0, 8'h00, "R1 R4 reset ctrl 00h");
    write_reg(5'h1C, 8'h50); do_line(1'b1, -1, 0, 8'h00, "R3 R4 track");
    write_reg(5'h1C, 8'h37); do_line(1'b1, -1, 0, 8'h00, "R3 R5");
    write_reg(5'h1C, 8'hF1); do_line(1'b1, -1, 0, 8'h00, "R3 R5 max rise");
    write_reg(5'h1C, 8'h0F); do_line(1'b1, -1, 0, 8'h00, "R5 max fall R9");
    write_reg(5'h1C, 8'hF0); do_line(1'b1, -1, 0, 8'h00, "R4 max rise track");
    write_reg(5'h1B, 8'h22); do_line(1'b1, -1, 0, 8'h00, "R2 other address");
    do_line(1'b1, 300, 2, 8'h11, "R2 stray write in window");
    do_line(1'b0, -1, 0, 8'h00, "R6 disabled line");
    do_line(1'b1, 200, 3, 8'h00, "R6 abort window");
    do_line(1'b1, 100, 1, 8'h24, "R7 write in window");
    do_line(1'b1, -1, 0, 8'h00, "R7 next line");
    do_line(1'b1, 700, 3, 8'h01, "R8 restart");

    for (int k = 0; k < 14; k++) begin
      logic [7:0] d;
      int kind;
      d = 8'($urandom);
      if (k % 3 == 0) d[3:0] = 4'd0;
      write_reg(5'h1C, d);
      if ($urandom % 4 == 0) write_reg(5'($urandom), 8'($urandom));
      kind = int'($urandom % 4);
      do_line(($urandom % 5) != 0, (kind == 0) ? -1 : 50 + int'($urandom % 1200),
              kind, 8'($urandom), "R9 random");
      repeat (int'($urandom % 8)) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule